// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O

This block attaches to a processor bus and gives it three 8-bit parallel ports, called A, B and C. Port C is handled as two 4-bit halves. The upper half follows the same configuration group as port A, and the lower half follows port B. Each of the four groups is set as input or output by writing a configuration word. Output values are held in latches. Input values are read straight from the pins each time, with no latch in between.

The host bus has an active-low chip select, active-low read and write strobes, a 2-bit address and an 8-bit data path. The data path is split into an input bus and an output bus, and the output bus has its own enable. Reads are combinational. A write is committed on the clock edge that sees the write strobe rise while chip select was low.

The control address is write-only and takes two kinds of word. A word with bit 7 set redefines the direction of the four groups. A word with bit 7 clear sets or clears one bit of the port C latch and leaves the group directions alone. Each pin has its own output enable, so a board can place tri-state buffers at the pins.

Top module: `ppi_top`

## Requirements
- R1: With cs_n and rd_n both low, address 0 reads port A, address 1 reads port B and address 2 reads port C, with dout_oe high during the read.
- R2: dout_oe is low whenever cs_n or rd_n is high.
- R3: A read at address 3 (the control address) leaves dout_oe low.
- R4: While rst is high, and after it, every group is an input (all pin output enables low) and every output latch is zero.
- R5: A control word with bit 7 = 1 and bits 6:5 and bit 2 all zero loads the group directions: bit 4 for port A, bit 3 for C upper (pins 7:4), bit 1 for port B and bit 0 for C lower (pins 3:0). A bit value of 1 means input.
- R6: A control word with bit 7 = 1 and a nonzero value in bits 6:5 or bit 2 is ignored, and the directions stay as they were.
- R7: A control word with bit 7 = 0 writes bit 0 into the port C latch bit chosen by bits 3:1. Bits 6:4 are ignored. Every other port C latch bit and every group direction keeps its value.
- R8: A write to address 0, 1 or 2 loads that port's output latch, and the value appears on its output pins. The write takes effect when wr_n rises while cs_n is low. A write strobe with cs_n high changes nothing.
- R9: Reading a pin that is an output returns the latched value. Reading a pin that is an input returns the live pin level.
- R10: Each pin's output enable is the inverse of its group's input flag. The two port C halves are configured independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; committed on its rising edge |
| addr | input | 2 | Register select: 0=A, 1=B, 2=C, 3=control |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| dout_oe | output | 1 | Enable for dout |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-pin output enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-pin output enable |

## Verification
Some properties are checked by assertions on every cycle. These are that the data bus is never enabled when the block is deselected, when no read is in progress, or when the control address is read. Reset must leave every pin enable low. A port latch may change only in the cycle after a write strobe rises. A set/reset command and a rejected mode word must leave the group directions unchanged. Other behaviour can only be shown by the bench's scenarios. This covers the bit mapping of the configuration word, the independence of the two port C halves, the mix of latched and live bits when port C is read, the ignored bits 6:4 of a set/reset command, and a write strobe with chip select high having no effect.

// File: rtl/ppi_pkg.sv
// Package: shared widths, register selects and control-word bit positions
// for the three-port parallel I/O block.
// Assumes an 8-bit host data path. The control-word bit positions below are
// decoded by ppi_ctrl and must stay aligned with the host software view.
package ppi_pkg;

    localparam int PORT_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int HALF_W   = PORT_W / 2;
    localparam int BIT_IX_W = $clog2(PORT_W);

    // Register select decoded from the 2-bit address.
    typedef enum logic [ADDR_W-1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CTL = 2'd3
    } sel_e;

    // Group direction flags; 1 means the group is an input.
    typedef struct packed {
        logic in_a;
        logic in_cu;
        logic in_b;
        logic in_cl;
    } dir_t;

    localparam dir_t DIR_ALL_IN = '{in_a: 1'b1, in_cu: 1'b1, in_b: 1'b1, in_cl: 1'b1};

    // Control-word field positions.
    localparam int CW_KIND    = 7;  // 1 = direction word, 0 = bit set/reset
    localparam int CW_MODE_HI = 6;  // mode field A, upper bit
    localparam int CW_MODE_LO = 5;  // mode field A, lower bit
    localparam int CW_DIR_A   = 4;
    localparam int CW_DIR_CU  = 3;
    localparam int CW_MODE_B  = 2;  // mode field B
    localparam int CW_DIR_B   = 1;
    localparam int CW_DIR_CL  = 0;
    localparam int CW_IX_LO   = 1;  // bit set/reset index occupies [3:1]
    localparam int CW_VAL     = 0;  // bit set/reset value

endpackage

// File: rtl/ppi_bus_if.sv
// Module: ppi_bus_if
// Turns the asynchronous-style host write strobe into a single-cycle commit
// pulse in the block clock domain. Address and data are captured while the
// strobe is low, and the commit fires on the edge that sees the strobe high
// again, provided chip select was low in the previous sample.
// Assumes the strobes stay stable for at least one clock period each.
module ppi_bus_if
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] din,
    output logic              wr_commit,
    output sel_e              wr_sel,
    output logic [PORT_W-1:0] wr_data
);

    logic              wr_q;
    logic              cs_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PORT_W-1:0] data_q;

    // Sample strobe and select every cycle for rising-edge detection.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b1;
            cs_q <= 1'b1;
        end else begin
            wr_q <= wr_n;
            cs_q <= cs_n;
        end
    end

    // Hold address and data captured while the write strobe is low.
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (!wr_n) begin
            addr_q <= addr;
            data_q <= din;
        end
    end

    // Commit on the strobe's rising edge when the chip was selected.
    always_comb begin
        wr_commit = !wr_q && wr_n && !cs_q;
        wr_sel    = sel_e'(addr_q);
        wr_data   = data_q;
    end

    // A commit is a single-cycle pulse.
    a_r8_commit_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> !wr_commit);

endmodule

// File: rtl/ppi_ctrl.sv
// Module: ppi_ctrl
// Decodes control-address writes. A direction word (bit 7 set) whose mode
// fields are all zero updates the four group input flags. A direction word
// with a nonzero mode field is dropped. A set/reset word (bit 7 clear) is
// passed on to the port C latch as an index/value pair.
// Assumes wr_commit is a single-cycle pulse from ppi_bus_if.
module ppi_ctrl
    import ppi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_commit,
    input  sel_e                wr_sel,
    input  logic [PORT_W-1:0]   wr_data,
    output dir_t                dir,
    output logic                bit_we,
    output logic [BIT_IX_W-1:0] bit_idx,
    output logic                bit_val
);

    logic ctl_wr;
    logic mode_ok;
    logic dir_we;

    // Classify a control-address write.
    always_comb begin
        ctl_wr  = wr_commit && (wr_sel == SEL_CTL);
        mode_ok = (wr_data[CW_MODE_HI] == 1'b0) && (wr_data[CW_MODE_LO] == 1'b0)
                  && (wr_data[CW_MODE_B] == 1'b0);
        dir_we  = ctl_wr && wr_data[CW_KIND] && mode_ok;
        bit_we  = ctl_wr && !wr_data[CW_KIND];
        bit_idx = wr_data[CW_IX_LO +: BIT_IX_W];
        bit_val = wr_data[CW_VAL];
    end

    // Direction register: all groups input after reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            dir <= DIR_ALL_IN;
        end else if (dir_we) begin
            dir.in_a  <= wr_data[CW_DIR_A];
            dir.in_cu <= wr_data[CW_DIR_CU];
            dir.in_b  <= wr_data[CW_DIR_B];
            dir.in_cl <= wr_data[CW_DIR_CL];
        end
    end

    // A set/reset command leaves every group direction untouched.
    a_r7_bsr_keeps_dirs: assert property (@(posedge clk) disable iff (rst)
        (wr_commit && wr_sel == SEL_CTL && !wr_data[CW_KIND]) |=> $stable(dir));

    // A direction word with an unsupported mode field is ignored.
    a_r6_bad_mode_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_commit && wr_sel == SEL_CTL && wr_data[CW_KIND]
         && (wr_data[CW_MODE_HI] || wr_data[CW_MODE_LO] || wr_data[CW_MODE_B]))
        |=> $stable(dir));

endmodule

// File: rtl/ppi_port.sv
// Module: ppi_port
// One parallel port: an output latch, per-pin output enables derived from
// NGRP equal-width direction groups, and the read-back value (latch for
// output pins, live pin for input pins). With HAS_BIT set, the latch also
// accepts single-bit set/reset updates.
// Assumes W is divisible by NGRP and that a byte write and a bit write never
// occur in the same cycle (both come from one commit pulse).
module ppi_port #(
    parameter int W       = 8,
    parameter int NGRP    = 1,
    parameter bit HAS_BIT = 1'b0,
    localparam int GW     = W / NGRP,
    localparam int IW     = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [W-1:0]    wdata,
    input  logic            bit_we,
    input  logic [IW-1:0]   bit_idx,
    input  logic            bit_val,
    input  logic [NGRP-1:0] grp_in,
    input  logic [W-1:0]    pin,
    output logic [W-1:0]    q,
    output logic [W-1:0]    oe,
    output logic [W-1:0]    rd_val
);

    logic bit_en;

    // Bit-update path exists only for the variant that needs it.
    generate
        if (HAS_BIT) begin : g_bit
            assign bit_en = bit_we;
        end else begin : g_nobit
            assign bit_en = 1'b0;
        end
    endgenerate

    // Output latch: cleared by reset, loaded by byte or single-bit writes.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end else if (bit_en) begin
            q[bit_idx] <= bit_val;
        end
    end

    // Per-pin enable and read-back selection.
    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            assign oe[i]     = ~grp_in[i / GW];
            assign rd_val[i] = grp_in[i / GW] ? pin[i] : q[i];
        end
    endgenerate

    // The latch moves only in the cycle after a byte or bit write.
    a_r8_latch_on_write: assert property (@(posedge clk) disable iff (rst)
        (!we && !bit_en) |=> $stable(q) || $past(rst));

endmodule

// File: rtl/ppi_top.sv
// Module: ppi_top
// Three-port parallel I/O peripheral. Host writes go through ppi_bus_if,
// control words through ppi_ctrl, and each port has a ppi_port instance.
// Reads are a combinational multiplexer onto dout, enabled only for the
// three port addresses while selected and read-strobed.
// Assumes a synchronous active-high reset and host strobes that are slow
// compared with clk.
module ppi_top
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] din,
    output logic [PORT_W-1:0] dout,
    output logic              dout_oe,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe
);

    logic                wr_commit;
    sel_e                wr_sel;
    logic [PORT_W-1:0]   wr_data;
    dir_t                dir;
    logic                bit_we;
    logic [BIT_IX_W-1:0] bit_idx;
    logic                bit_val;
    logic [PORT_W-1:0]   rd_a, rd_b, rd_c;
    logic                we_a, we_b, we_c;

    ppi_bus_if u_bus (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .din       (din),
        .wr_commit (wr_commit),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data)
    );

    ppi_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_commit (wr_commit),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .dir       (dir),
        .bit_we    (bit_we),
        .bit_idx   (bit_idx),
        .bit_val   (bit_val)
    );

    // Per-port byte write enables from the committed select.
    always_comb begin
        we_a = wr_commit && (wr_sel == SEL_A);
        we_b = wr_commit && (wr_sel == SEL_B);
        we_c = wr_commit && (wr_sel == SEL_C);
    end

    ppi_port #(.W(PORT_W), .NGRP(1), .HAS_BIT(1'b0)) u_port_a (
        .clk     (clk),
        .rst     (rst),
        .we      (we_a),
        .wdata   (wr_data),
        .bit_we  (1'b0),
        .bit_idx ('0),
        .bit_val (1'b0),
        .grp_in  (dir.in_a),
        .pin     (pa_in),
        .q       (pa_out),
        .oe      (pa_oe),
        .rd_val  (rd_a)
    );

    ppi_port #(.W(PORT_W), .NGRP(1), .HAS_BIT(1'b0)) u_port_b (
        .clk     (clk),
        .rst     (rst),
        .we      (we_b),
        .wdata   (wr_data),
        .bit_we  (1'b0),
        .bit_idx ('0),
        .bit_val (1'b0),
        .grp_in  (dir.in_b),
        .pin     (pb_in),
        .q       (pb_out),
        .oe      (pb_oe),
        .rd_val  (rd_b)
    );

    // Port C: group 1 is the upper half (with A), group 0 the lower (with B).
    ppi_port #(.W(PORT_W), .NGRP(2), .HAS_BIT(1'b1)) u_port_c (
        .clk     (clk),
        .rst     (rst),
        .we      (we_c),
        .wdata   (wr_data),
        .bit_we  (bit_we),
        .bit_idx (bit_idx),
        .bit_val (bit_val),
        .grp_in  ({dir.in_cu, dir.in_cl}),
        .pin     (pc_in),
        .q       (pc_out),
        .oe      (pc_oe),
        .rd_val  (rd_c)
    );

    // Read multiplexer and bus enable; control address is not readable.
    always_comb begin
        unique case (sel_e'(addr))
            SEL_A:   dout = rd_a;
            SEL_B:   dout = rd_b;
            SEL_C:   dout = rd_c;
            default: dout = '0;
        endcase
        dout_oe = !cs_n && !rd_n && (sel_e'(addr) != SEL_CTL);
    end

    // Bus is quiet when deselected or not reading.
    a_r2_bus_idle: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> !dout_oe);

    // Control address never drives the bus.
    a_r3_ctl_unreadable: assert property (@(posedge clk) disable iff (rst)
        (addr == 2'd3) |-> !dout_oe);

    // Reset leaves all pins as inputs.
    a_r4_reset_inputs: assert property (@(posedge clk)
        $past(rst) |-> (pa_oe == '0) && (pb_oe == '0) && (pc_oe == '0));

    // Port A latch changes only after a write-strobe rise.
    a_r8_pa_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pa_out) && !$past(rst)) |-> ($past(wr_n, 1) && !$past(wr_n, 2)));

endmodule

// File: tb/tb_ppi_top.sv
// Bench: scoreboard style. Each check pushes its expected value into a
// queue and posts the observed value; a monitor process pops and compares.
module tb_ppi_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n, rd_n, wr_n;
    logic [1:0] addr;
    logic [7:0] din;
    logic [7:0] dout;
    logic       dout_oe;
    logic [7:0] pa_in, pa_out, pa_oe;
    logic [7:0] pb_in, pb_out, pb_oe;
    logic [7:0] pc_in, pc_out, pc_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        logic [8:0] exp;
    } item_t;

    item_t      exp_q[$];
    logic [8:0] obs;
    event       obs_ev;

    always #10 clk = ~clk;  // 50 MHz

    ppi_top dut (
        .clk (clk), .rst (rst), .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n),
        .addr (addr), .din (din), .dout (dout), .dout_oe (dout_oe),
        .pa_in (pa_in), .pa_out (pa_out), .pa_oe (pa_oe),
        .pb_in (pb_in), .pb_out (pb_out), .pb_oe (pb_oe),
        .pc_in (pc_in), .pc_out (pc_out), .pc_oe (pc_oe)
    );

    // Monitor: pop the expected item and compare with the observation.
    initial begin
        forever begin
            item_t it;
            @(obs_ev);
            it = exp_q.pop_front();
            n_run++;
            if (obs !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, obs, it.exp);
            end
        end
    end

    // Driver side of the scoreboard.
    task automatic check(input string tag, input logic [8:0] exp, input logic [8:0] act);
        exp_q.push_back('{tag, exp});
        obs = act;
        ->obs_ev;
        #1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
        @(negedge clk);
        cs_n = sel_n; addr = a; din = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic sel_n, output logic [8:0] r);
        @(negedge clk);
        cs_n = sel_n; addr = a; rd_n = 1'b0;
        #2;
        r = {dout_oe, dout};
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 pa_oe in reset", 9'h000, {1'b0, pa_oe});
        check("R4 pc_oe in reset", 9'h000, {1'b0, pc_oe});
        check("R4 pa_out in reset", 9'h000, {1'b0, pa_out});
        rst = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] r;
        rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        addr = 2'd0; din = 8'h00;
        pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
        do_reset();
        check("R4 pb_oe after reset", 9'h000, {1'b0, pb_oe});

        // R1/R9: all inputs, reads return live pins.
        bus_read(2'd0, 1'b0, r); check("R1 read A", 9'h15A, r);
        bus_read(2'd1, 1'b0, r); check("R1 read B", 9'h1C3, r);
        bus_read(2'd2, 1'b0, r); check("R1 read C", 9'h196, r);
        bus_read(2'd3, 1'b0, r); check("R3 read ctl", 1'b0, {r[8], 8'h00});
        bus_read(2'd0, 1'b1, r); check("R2 deselected", 1'b0, {r[8], 8'h00});
        check("R2 idle oe", 9'h000, {dout_oe, 8'h00});

        // R5/R10: all outputs.
        bus_write(2'd3, 8'h80, 1'b0);
        check("R5 pa_oe", 9'h0FF, {1'b0, pa_oe});
        check("R5 pb_oe", 9'h0FF, {1'b0, pb_oe});
        check("R10 pc_oe", 9'h0FF, {1'b0, pc_oe});

        // R8/R9: latched output and read-back.
        bus_write(2'd0, 8'h3C, 1'b0);
        check("R8 pa_out", 9'h03C, {1'b0, pa_out});
        pa_in = 8'h00;
        bus_read(2'd0, 1'b0, r); check("R9 read output A", 9'h13C, r);
        bus_write(2'd1, 8'h11, 1'b1);
        check("R8 write deselected", 9'h000, {1'b0, pb_out});

        // R10: C halves independent.
        bus_write(2'd3, 8'h88, 1'b0);
        check("R10 C upper input", 9'h00F, {1'b0, pc_oe});
        bus_write(2'd3, 8'h81, 1'b0);
        check("R10 C lower input", 9'h0F0, {1'b0, pc_oe});
        bus_write(2'd3, 8'h88, 1'b0);
        bus_write(2'd2, 8'hA5, 1'b0);
        check("R8 pc_out", 9'h0A5, {1'b0, pc_out});
        pc_in = 8'h70;
        bus_read(2'd2, 1'b0, r); check("R9 mixed C read", 9'h175, r);

        // R7: bit set/reset on port C.
        bus_write(2'd3, 8'h80, 1'b0);
        bus_write(2'd2, 8'h00, 1'b0);
        bus_write(2'd3, 8'h0F, 1'b0);
        check("R7 set bit7", 9'h080, {1'b0, pc_out});
        bus_write(2'd3, 8'h75, 1'b0);
        check("R7 set bit2 high bits ignored", 9'h084, {1'b0, pc_out});
        check("R7 A dir kept", 9'h0FF, {1'b0, pa_oe});
        bus_write(2'd3, 8'h0E, 1'b0);
        check("R7 clear bit7", 9'h004, {1'b0, pc_out});
        bus_write(2'd3, 8'h92, 1'b0);
        check("R5 A input", 9'h000, {1'b0, pa_oe});
        bus_write(2'd3, 8'h01, 1'b0);
        check("R7 B dir kept", 9'h000, {1'b0, pb_oe});
        check("R7 set bit0", 9'h005, {1'b0, pc_out});

        // R6: unsupported mode fields ignored.
        bus_write(2'd3, 8'h80, 1'b0);
        bus_write(2'd3, 8'hB2, 1'b0);
        check("R6 mode A field", 9'h0FF, {1'b0, pa_oe});
        bus_write(2'd3, 8'h86, 1'b0);
        check("R6 mode B field", 9'h0FF, {1'b0, pb_oe});

        // R4: reset after activity.
        do_reset();
        check("R4 pc_out after reset", 9'h000, {1'b0, pc_out});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule